// File: doc/BRIEF.md
# Keyboard LED Command Decoder

This block sits on the keyboard side of a host-to-keyboard serial link. A small asynchronous receiver turns the incoming line into bytes. A decoder then reads each byte as a command. The command can update eight LED latches, or it can reset the keyboard controller. The link runs at about 19.53 kHz. The parameter `CLK_PER_TICK` sets how many system clocks make one sixteenth of a bit, so that rate can be reached from any system clock.

The LEDs fall into two groups of four, and a single command loads one whole group. The high nibble of the command selects the group and the low nibble supplies the new LED states. To show an error code, the host sends one command for each group, one after the other. A dedicated reset code turns every LED off and raises a one-cycle pulse toward the keyboard controller. All other bytes do nothing.

Top module: `kb_led_ctrl`

## Requirements
- R1: While `rst_ni` is low, `leds_o` is 0 and `kbd_rst_o` is 1. At the first clock edge after `rst_ni` is released, `kbd_rst_o` returns to 0.
- R2: A byte 0xA0..0xAF copies its low nibble into `leds_o[7:4]`. The bit order is bit 3 to Overtype (`leds_o[7]`), bit 2 to Lock, bit 1 to F1 and bit 0 to F2 (`leds_o[4]`). `leds_o[3:0]` stays unchanged.
- R3: A byte 0xB0..0xBF copies its low nibble into `leds_o[3:0]`. The bit order is bit 3 to F3 (`leds_o[3]`), bit 2 to F8, bit 1 to F9 and bit 0 to F10 (`leds_o[0]`). `leds_o[7:4]` stays unchanged.
- R4: The byte 0x92 clears all eight LEDs and drives `kbd_rst_o` high for exactly one clock cycle. Its high level coincides with the cleared LEDs.
- R5: Any byte that is not 0x92 and not in 0xA0..0xBF leaves `leds_o` unchanged and does not pulse `kbd_rst_o`.
- R6: Two commands sent back to back combine. For example, 0xB0 followed by 0xAE leaves `leds_o` at 0xE0.
- R7: The line format is 8N1: one start bit, eight data bits sent LSB first, and one stop bit. Idle is high. One bit lasts 16*`CLK_PER_TICK` clocks. Each bit is sampled at its middle. A byte takes effect on `leds_o` before the end of its stop bit.
- R8: A frame whose stop bit samples low is discarded. The receiver then waits for the line to go high before it accepts a new start bit, and the following good frame is decoded normally.
- R9: A low pulse shorter than half a bit is not taken as a start bit and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line from the host, idle high |
| leds_o | output | 8 | LED latches: [7] Overtype, [6] Lock, [5] F1, [4] F2, [3] F3, [2] F8, [1] F9, [0] F10 |
| kbd_rst_o | output | 1 | Keyboard controller reset pulse |

## Verification
The bench builds the block with `CLK_PER_TICK` = 2, so one bit lasts 32 clocks and a frame lasts about 350 clocks. At that size every byte value from 0x00 to 0xFF can be sent as a real serial frame.

Before the sweep, the LEDs are preloaded with a mixed pattern. This makes any wrong update by an ignored byte visible on the outputs. A reference model of the latches in the bench checks the LED state and the reset-pulse count after every frame. Short directed cases then cover:
- the two-command error code,
- a frame with a bad stop bit,
- a glitch on the start bit,
- a reset in the middle of a run.

// File: rtl/kb_led_pkg.sv
package kb_led_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  localparam logic [7:0] CMD_KBD_RESET = 8'h92;
  localparam logic [3:0] GRP_UPPER     = 4'hA;
  localparam logic [3:0] GRP_LOWER     = 4'hB;
  localparam int unsigned GRP_W        = 4;
  localparam int unsigned NUM_GRP      = 2;
  localparam int unsigned LED_W        = GRP_W * NUM_GRP;
endpackage

// File: rtl/kb_uart_rx.sv
module kb_uart_rx
  import kb_led_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK = 400,
  parameter int unsigned OVS          = 16,
  parameter int unsigned DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned DIV_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam int unsigned OVS_W = $clog2(OVS);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_TICK - 1);
  localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);
  localparam logic [OVS_W-1:0] OVS_MID  = OVS_W'(OVS / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  logic [1:0]        sync_q;
  logic              rx;
  rx_state_e         state_q;
  logic [DIV_W-1:0]  div_q;
  logic [OVS_W-1:0]  ovs_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              tick;

  assign rx   = sync_q[1];
  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      div_q   <= '0;
      ovs_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      vld_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      vld_o <= 1'b0;
      if (state_q == RX_IDLE || state_q == RX_HOLD) div_q <= '0;
      else div_q <= tick ? '0 : div_q + 1'b1;
      unique case (state_q)
        RX_IDLE: begin
          ovs_q <= '0;
          idx_q <= '0;
          if (!rx) state_q <= RX_START;
        end
        RX_START: if (tick) begin
          if (ovs_q == OVS_MID) begin
            ovs_q   <= '0;
            state_q <= rx ? RX_IDLE : RX_DATA; // reject glitch
          end else ovs_q <= ovs_q + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (ovs_q == OVS_LAST) begin
            ovs_q   <= '0;
            shift_q <= {rx, shift_q[DATA_W-1:1]};
            idx_q   <= idx_q + 1'b1;
            if (idx_q == IDX_LAST) state_q <= RX_STOP;
          end else ovs_q <= ovs_q + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (ovs_q == OVS_LAST) begin
            ovs_q <= '0;
            if (rx) begin
              vld_o   <= 1'b1;
              data_o  <= shift_q;
              state_q <= RX_IDLE;
            end else state_q <= RX_HOLD; // framing error
          end else ovs_q <= ovs_q + 1'b1;
        end
        RX_HOLD: if (rx) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kb_led_dec.sv
module kb_led_dec
  import kb_led_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [7:0]       cmd_i,
  output logic [LED_W-1:0] leds_o,
  output logic             kbd_rst_o
);
  logic [NUM_GRP-1:0] grp_hit;

  // group 0 = lower latches (0xBx), group 1 = upper latches (0xAx)
  assign grp_hit[0] = vld_i && (cmd_i[7:4] == GRP_LOWER);
  assign grp_hit[1] = vld_i && (cmd_i[7:4] == GRP_UPPER);

  logic clr;
  assign clr = vld_i && (cmd_i == CMD_KBD_RESET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kbd_rst_o <= 1'b1;
    else         kbd_rst_o <= clr;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         leds_o[g*GRP_W +: GRP_W] <= '0;
      else if (clr)        leds_o[g*GRP_W +: GRP_W] <= '0;
      else if (grp_hit[g]) leds_o[g*GRP_W +: GRP_W] <= cmd_i[GRP_W-1:0];
    end
  end
endmodule

// File: rtl/kb_led_ctrl.sv
module kb_led_ctrl
  import kb_led_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK = 400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rxd_i,
  output logic [7:0] leds_o,
  output logic       kbd_rst_o
);
  logic       byte_vld;
  logic [7:0] byte_data;

  kb_uart_rx #(
    .CLK_PER_TICK(CLK_PER_TICK),
    .OVS         (16),
    .DATA_W      (8)
  ) u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rxd_i (rxd_i),
    .vld_o (byte_vld),
    .data_o(byte_data)
  );

  kb_led_dec u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (byte_vld),
    .cmd_i    (byte_data),
    .leds_o   (leds_o),
    .kbd_rst_o(kbd_rst_o)
  );
endmodule

// File: rtl/kb_led_ctrl_chk.sv
module kb_led_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       byte_vld_i,
  input logic [7:0] byte_i,
  input logic [7:0] leds_i,
  input logic       kbd_rst_i
);
  // R4
  kbd_rst_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_rst_i |=> !kbd_rst_i);

  // R4
  kbd_rst_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_rst_i |-> (leds_i == 8'h00));

  // R5
  leds_idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(byte_vld_i) |-> $stable(leds_i));

  // R2
  upper_keeps_lower_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(byte_vld_i && byte_i[7:4] == 4'hA) |-> (leds_i[3:0] == $past(leds_i[3:0])));

  // R3
  lower_keeps_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(byte_vld_i && byte_i[7:4] == 4'hB) |-> (leds_i[7:4] == $past(leds_i[7:4])));

  // R7
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i |=> !byte_vld_i);
endmodule

bind kb_led_ctrl kb_led_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .byte_vld_i(byte_vld),
  .byte_i    (byte_data),
  .leds_i    (leds_o),
  .kbd_rst_i (kbd_rst_o)
);

// File: tb/tb_kb_led_ctrl.sv
`timescale 1ns/1ps
module tb_kb_led_ctrl;
  localparam int unsigned TICK = 2;
  localparam int unsigned BIT  = TICK * 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] leds;
  logic       kbd_rst;

  int total = 0;
  int bad   = 0;
  int pulses = 0;
  bit done  = 1'b0;
  logic [7:0] exp_leds = 8'h00;

  always #4 clk = ~clk;

  kb_led_ctrl #(.CLK_PER_TICK(TICK)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .rxd_i    (rxd),
    .leds_o   (leds),
    .kbd_rst_o(kbd_rst)
  );

  always @(posedge clk) if (rst_ni && kbd_rst) pulses <= pulses + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop_ok);
    hold_line(1'b0, BIT);
    for (int i = 0; i < 8; i++) hold_line(b[i], BIT);
    hold_line(stop_ok, BIT);
    hold_line(1'b1, BIT);
  endtask

  // expected effect of one good frame
  function automatic logic [7:0] model(input logic [7:0] cur, input logic [7:0] b);
    if (b == 8'h92)          return 8'h00;
    if (b[7:4] == 4'hA)      return {b[3:0], cur[3:0]};
    if (b[7:4] == 4'hB)      return {cur[7:4], b[3:0]};
    return cur;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 leds in reset", leds, 8'h00);
    chk("R1 kbd_rst in reset", kbd_rst, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 kbd_rst released", kbd_rst, 1'b0);
    repeat (4) @(negedge clk);

    // R2 R3 preload
    send(8'hA5, 1'b1);
    chk("R2 upper load", leds, 8'h50);
    send(8'hBA, 1'b1);
    chk("R3 lower load", leds, 8'h5A);
    exp_leds = 8'h5A;

    // R7 full byte sweep through the serial path; R2 R3 R4 R5
    for (int b = 0; b < 256; b++) begin
      pulses = 0;
      send(8'(b), 1'b1);
      exp_leds = model(exp_leds, 8'(b));
      chk($sformatf("R7 sweep byte %02h leds", b), leds, exp_leds);
      if (b == 'h92) chk("R4 reset pulse count", pulses, 1);
      else           chk($sformatf("R5 no pulse byte %02h", b), pulses, 0);
    end

    // R6 error code display
    send(8'hB0, 1'b1);
    send(8'hAE, 1'b1);
    chk("R6 error code E0", leds, 8'hE0);
    exp_leds = 8'hE0;

    // R8 bad stop bit discarded, then recovery
    send(8'h93, 1'b0);
    chk("R8 bad stop ignored", leds, 8'hE0);
    send(8'hA3, 1'b0);
    chk("R8 bad stop upper ignored", leds, 8'hE0);
    send(8'hB7, 1'b1);
    chk("R8 recovery frame", leds, 8'hE7);

    // R9 short glitch rejected
    hold_line(1'b0, BIT / 2 - 6);
    hold_line(1'b1, 2 * BIT);
    chk("R9 glitch ignored", leds, 8'hE7);
    send(8'hA1, 1'b1);
    chk("R9 frame after glitch", leds, 8'h17);

    // R4 reset command after nonzero state
    pulses = 0;
    send(8'h92, 1'b1);
    chk("R4 clear by command", leds, 8'h00);
    chk("R4 one pulse", pulses, 1);

    // R1 system reset mid-run
    send(8'hAF, 1'b1);
    send(8'hBF, 1'b1);
    chk("R2 R3 all on", leds, 8'hFF);
    rst_ni = 1'b0;
    #1;
    chk("R1 async clear", leds, 8'h00);
    chk("R1 kbd_rst asserted", kbd_rst, 1'b1);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 pulse ends", kbd_rst, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule